// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Selectable Framing

This block turns parallel bytes into an asynchronous serial bit stream on a single line. A byte enters through a valid/ready handshake. The block then sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a stop period of one, one and a half, or two bit times. The framing inputs are captured when a byte is accepted. A system can therefore change them for the next frame while the current frame is still going out.

Bit timing comes from a one-cycle oversample strobe at sixteen times the bit rate. Every bit lasts sixteen strobes, which is what makes a half-bit stop period possible. A held break input pulls the line low and abandons any frame in progress. A request-to-send output either follows a control bit or passes an external clock through when an override input is set.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is clear, `txOut` is 1 and `txReady` is 1. A byte is accepted on a rising clock edge where `txValid` and `txReady` are both 1.
- R2: Each bit lasts 16 `tickX16` strobes. The start bit is 0, and the data bits follow least significant bit first. `txOut` changes on the clock edge after the strobe cycle that ends a bit.
- R3: `lenSel` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8.
- R4: With `stopLong`=0, the stop period is 16 strobes of 1. With `stopLong`=1, it is 24 strobes for 5-bit words and 32 strobes for 6-, 7- and 8-bit words.
- R5: With `parEn`=0, the stop period follows the last data bit directly. With `parEn`=1, one 16-strobe parity bit sits between the data and the stop period.
- R6: With `parForce`=0, `parEven`=1 makes the parity bit the XOR of the sent data bits (even parity). `parEven`=0 makes it the inverse (odd parity).
- R7: With `parEn`=1 and `parForce`=1, the parity bit is the constant `!parEven`, whatever the data.
- R8: While `breakOn`=1, `txOut` is 0 from the next clock edge and `txReady` is 0. Any frame in progress is abandoned, and `txValid` has no effect. The clock edge after release returns the line to 1 with `txReady`=1.
- R9: `txReady` is 0 from the accepting edge until the edge that ends the last stop strobe. It is 1 again in the following cycle.
- R10: The data and the framing inputs are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R11: `rtsOut` equals `rtsCtl` when `rtsClkSel`=0, and equals `rtsClkIn` when `rtsClkSel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickX16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte offered |
| txReady | output | 1 | Block can accept a byte |
| lenSel | input | 2 | Data length select (5 to 8 bits) |
| stopLong | input | 1 | Long stop period select |
| parEn | input | 1 | Parity bit enable |
| parEven | input | 1 | Even parity select (0: odd) |
| parForce | input | 1 | Constant parity bit select |
| breakOn | input | 1 | Hold the line low |
| rtsCtl | input | 1 | Direct level for `rtsOut` |
| rtsClkSel | input | 1 | Route `rtsClkIn` to `rtsOut` |
| rtsClkIn | input | 1 | Clock to pass through |
| txOut | output | 1 | Serial line, idles high |
| rtsOut | output | 1 | Request-to-send output |

## Verification
The bench rebuilds the whole line waveform by sampling once per strobe and comparing against the expected bit for that strobe index. Directed frames separate the three stop lengths and both parity senses. Forced parity is tried with data whose computed parity differs from the forced value, so forced and computed parity cannot be confused. Random frames use irregular strobe spacing, and the framing inputs are scrambled right after acceptance, which shows that the configuration is captured and not read live. A break asserted mid-frame, followed by release, separates true abandonment from merely pausing the frame.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;
  localparam int LEN_W    = $clog2(DATA_W - MIN_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } txPhase_t;

  typedef enum logic [1:0] {
    LINE_MARK, LINE_SPACE, LINE_DATA, LINE_PARITY
  } lineSel_t;

  typedef struct packed {
    logic [LEN_W-1:0] lenSel;
    logic             stopLong;
    logic             parEn;
    logic             parEven;
    logic             parForce;
  } frameCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    logic     lineHold;
    lineSel_t lineSel;
  } txStrobe_t;
endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uart_frame_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickX16,
  input  logic             txValid,
  input  logic             breakOn,
  input  logic [LEN_W-1:0] heldLen,
  input  logic             heldStopLong,
  input  logic             heldParEn,
  output logic             txReady,
  output txStrobe_t        strobe
);
  localparam int STOP_ONE  = OVERSAMPLE;
  localparam int STOP_HALF = OVERSAMPLE + OVERSAMPLE / 2;
  localparam int STOP_TWO  = 2 * OVERSAMPLE;
  localparam int CNT_W     = $clog2(STOP_TWO);
  localparam int IDX_W     = $clog2(DATA_W);

  txPhase_t         phase, nextPhase;
  logic [CNT_W-1:0] tickCnt, tickLimit, stopTicks;
  logic [IDX_W-1:0] bitIdx, lastIdx;
  logic             bitEnd;

  always_comb begin
    if (!heldStopLong)       stopTicks = CNT_W'(STOP_ONE - 1);
    else if (heldLen == '0)  stopTicks = CNT_W'(STOP_HALF - 1);
    else                     stopTicks = CNT_W'(STOP_TWO - 1);
    tickLimit = (phase == ST_STOP) ? stopTicks : CNT_W'(OVERSAMPLE - 1);
  end

  assign lastIdx = IDX_W'(MIN_BITS - 1) + IDX_W'(heldLen);
  assign bitEnd  = tickX16 && (tickCnt == tickLimit);

  always_comb begin
    unique case (phase)
      ST_START:  nextPhase = ST_DATA;
      ST_DATA:   nextPhase = (bitIdx != lastIdx) ? ST_DATA
                           : (heldParEn ? ST_PARITY : ST_STOP);
      ST_PARITY: nextPhase = ST_STOP;
      default:   nextPhase = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || breakOn) begin
      phase   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (phase == ST_IDLE) begin
      tickCnt <= '0;
      bitIdx  <= '0;
      if (txValid) phase <= ST_START;
    end else if (tickX16) begin
      if (bitEnd) begin
        tickCnt <= '0;
        phase   <= nextPhase;
        bitIdx  <= (phase == ST_DATA) ? bitIdx + 1'b1 : '0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign txReady = (phase == ST_IDLE) && !breakOn;

  always_comb begin
    strobe.load     = txValid && txReady;
    strobe.shift    = (phase == ST_DATA) && bitEnd;
    strobe.lineHold = breakOn;
    unique case (phase)
      ST_START:  strobe.lineSel = LINE_SPACE;
      ST_DATA:   strobe.lineSel = LINE_DATA;
      ST_PARITY: strobe.lineSel = LINE_PARITY;
      default:   strobe.lineSel = LINE_MARK;
    endcase
  end
endmodule

// File: rtl/uft_datapath.sv
module uft_datapath
  import uart_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  frameCfg_t         liveCfg,
  input  txStrobe_t         strobe,
  input  logic              rtsCtl,
  input  logic              rtsClkSel,
  input  logic              rtsClkIn,
  output frameCfg_t         heldCfg,
  output logic              txOut,
  output logic              rtsOut
);
  logic [DATA_W-1:0] wordMask, shiftReg;
  logic              dataPar, nextPar, parBit, lineLevel;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    if (g < MIN_BITS) begin : g_fixed
      assign wordMask[g] = 1'b1;
    end else begin : g_sel
      assign wordMask[g] = (liveCfg.lenSel >= LEN_W'(g - MIN_BITS + 1));
    end
  end

  assign dataPar = ^(txData & wordMask);
  assign nextPar = liveCfg.parForce ? ~liveCfg.parEven
                 : (liveCfg.parEven ? dataPar : ~dataPar);

  always_comb begin
    unique case (strobe.lineSel)
      LINE_SPACE:  lineLevel = 1'b0;
      LINE_DATA:   lineLevel = shiftReg[0];
      LINE_PARITY: lineLevel = parBit;
      default:     lineLevel = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      heldCfg  <= '0;
      txOut    <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftReg <= txData;
        parBit   <= nextPar;
        heldCfg  <= liveCfg;
      end else if (strobe.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      txOut <= strobe.lineHold ? 1'b0 : lineLevel;
    end
  end

  assign rtsOut = rtsClkSel ? rtsClkIn : rtsCtl;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickX16,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic              stopLong,
  input  logic              parEn,
  input  logic              parEven,
  input  logic              parForce,
  input  logic              breakOn,
  input  logic              rtsCtl,
  input  logic              rtsClkSel,
  input  logic              rtsClkIn,
  output logic              txOut,
  output logic              rtsOut
);
  frameCfg_t liveCfg, heldCfg;
  txStrobe_t strobe;

  assign liveCfg = '{lenSel: lenSel, stopLong: stopLong, parEn: parEn,
                     parEven: parEven, parForce: parForce};

  uft_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickX16(tickX16), .txValid(txValid),
    .breakOn(breakOn), .heldLen(heldCfg.lenSel),
    .heldStopLong(heldCfg.stopLong), .heldParEn(heldCfg.parEn),
    .txReady(txReady), .strobe(strobe)
  );

  uft_datapath u_dp (
    .clk(clk), .rstN(rstN), .txData(txData), .liveCfg(liveCfg),
    .strobe(strobe), .rtsCtl(rtsCtl), .rtsClkSel(rtsClkSel),
    .rtsClkIn(rtsClkIn), .heldCfg(heldCfg), .txOut(txOut), .rtsOut(rtsOut)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic breakOn,
  input logic txOut
);
  // R1: an idle, ready cycle leaves the line high on the next edge
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> txOut);

  // R2: an accepted byte shows a low start bit two edges later
  a_r2_start_space: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) ##1 !breakOn |=> !txOut);

  // R8: break pulls the line low on the next edge
  a_r8_break_space: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |=> !txOut);

  // R8: releasing break leaves the block idle and ready
  a_r8_release_ready: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakOn) |-> txReady);

  // R9: ready drops only after an accepted byte or under break
  a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) && !breakOn |-> $past(txValid));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .breakOn(breakOn), .txOut(txOut)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic clk = 1'b0, rstN = 1'b0, tickX16 = 1'b0;
  logic [7:0] txData = '0;
  logic txValid = 1'b0, txReady;
  logic [1:0] lenSel = '0;
  logic stopLong = 1'b0, parEn = 1'b0, parEven = 1'b0, parForce = 1'b0;
  logic breakOn = 1'b0, rtsCtl = 1'b0, rtsClkSel = 1'b0, rtsClkIn = 1'b0;
  logic txOut, rtsOut;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_frame_tx uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic expPar(logic [7:0] d, logic [1:0] len, logic pev, logic pf);
    logic p = 1'b0;
    if (pf) return !pev;
    for (int i = 0; i < 5 + int'(len); i++) p ^= d[i];
    return pev ? p : !p;
  endfunction

  function automatic int frameTicks(logic [1:0] len, logic sl, logic pe);
    int stopT = !sl ? 16 : (len == 2'd0 ? 24 : 32);
    return 16 * (1 + 5 + int'(len) + (pe ? 1 : 0)) + stopT;
  endfunction

  function automatic logic expBit(int idx, logic [7:0] d, logic [1:0] len,
                                  logic pe, logic pev, logic pf);
    int n = 5 + int'(len);
    int b = idx / 16;
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (pe && b == n + 1) return expPar(d, len, pev, pf);
    return 1'b1;
  endfunction

  // run n strobes with random spacing; optionally check the line level
  task automatic runTicks(input int n, input bit doChk, input logic expOut,
                          input string tag);
    int bad = 0;
    int gap = 0;
    int done = 0;
    while (done < n) begin
      bit doTick = (gap == 0);
      if (doTick) gap = $urandom_range(0, 2); else gap--;
      tickX16 = doTick;
      @(negedge clk);
      tickX16 = 1'b0;
      if (doTick) begin
        if (doChk && txOut !== expOut) bad++;
        done++;
      end
    end
    if (doChk) chk(bad == 0, tag, "line level over strobes", bad, 0);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] len,
                           input logic sl, input logic pe, input logic pev,
                           input logic pf, input bit mutate, input string tag);
    int total, idx, bad, badRdy, gap, firstIdx, firstAct, firstExp;
    @(negedge clk);
    txData = d; lenSel = len; stopLong = sl; parEn = pe; parEven = pev;
    parForce = pf; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    if (mutate) begin   // R10: scramble inputs after acceptance
      txData = 8'($urandom); lenSel = 2'($urandom); stopLong = 1'($urandom);
      parEn = 1'($urandom); parEven = 1'($urandom); parForce = 1'($urandom);
    end
    chk(txReady == 1'b0, "R9", "ready after accept", txReady, 0);
    total = frameTicks(len, sl, pe);
    idx = 0; bad = 0; badRdy = 0; gap = $urandom_range(0, 2);
    firstIdx = 0; firstAct = 0; firstExp = 0;
    while (idx < total) begin
      bit doTick = (gap == 0);
      if (doTick) gap = $urandom_range(0, 2); else gap--;
      tickX16 = doTick;
      @(negedge clk);
      tickX16 = 1'b0;
      if (doTick) begin
        logic e = expBit(idx, d, len, pe, pev, pf);
        if (txOut !== e) begin
          if (bad == 0) begin firstIdx = idx; firstAct = txOut; firstExp = e; end
          bad++;
        end
        if (txReady !== (idx == total - 1)) badRdy++;
        idx++;
      end
    end
    chk(bad == 0, tag, $sformatf("frame strobe %0d", firstIdx), firstAct, firstExp);
    chk(badRdy == 0, "R9", "ready only after last stop strobe", badRdy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txOut === 1'b1, "R1", "line after reset", txOut, 1);
    chk(txReady === 1'b1, "R1", "ready after reset", txReady, 1);
    runTicks(20, 1'b1, 1'b1, "R1");

    // directed framing cases
    sendFrame(8'hA5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 R4 (5 bits, 1.5 stop)");
    sendFrame(8'h3C, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 R5 R6 (8 bits, 2 stop, even)");
    sendFrame(8'h2B, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R5 R6 (6 bits, odd)");
    sendFrame(8'h01, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 (forced high)");
    sendFrame(8'h01, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7 (forced low)");
    sendFrame(8'h80, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 R5 (8 bits, no parity)");
    sendFrame(8'hF0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 (inputs changed mid-frame)");

    // random frames
    for (int i = 0; i < 40; i++)
      sendFrame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'b1, "R2 R3 R4 R5 R6 R7 R10 random");

    // break in mid-frame
    @(negedge clk);
    txData = 8'h00; lenSel = 2'd3; stopLong = 1'b1; parEn = 1'b0; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    runTicks(40, 1'b0, 1'b0, "R8");
    breakOn = 1'b1;
    @(negedge clk);
    chk(txOut === 1'b0, "R8", "line under break", txOut, 0);
    chk(txReady === 1'b0, "R8", "ready under break", txReady, 0);
    txValid = 1'b1;   // offered during break: must be ignored
    runTicks(30, 1'b1, 1'b0, "R8");
    chk(txReady === 1'b0, "R8", "ready still low under break", txReady, 0);
    txValid = 1'b0;
    @(negedge clk);
    breakOn = 1'b0;
    @(negedge clk);
    chk(txOut === 1'b1, "R8", "line after release", txOut, 1);
    chk(txReady === 1'b1, "R8", "ready after release", txReady, 1);
    runTicks(40, 1'b1, 1'b1, "R8");
    sendFrame(8'h5A, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 (clean frame after break)");

    // request-to-send output
    rtsClkSel = 1'b0; rtsCtl = 1'b1; #1;
    chk(rtsOut === 1'b1, "R11", "direct high", rtsOut, 1);
    rtsCtl = 1'b0; #1;
    chk(rtsOut === 1'b0, "R11", "direct low", rtsOut, 0);
    rtsClkSel = 1'b1; rtsClkIn = 1'b1; #1;
    chk(rtsOut === 1'b1, "R11", "clock passed high", rtsOut, 1);
    rtsCtl = 1'b1; rtsClkIn = 1'b0; #1;
    chk(rtsOut === 1'b0, "R11", "clock passed low", rtsOut, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule